// File: doc/BRIEF.md
# Bus Start Hunter with Armed Timeout Window

This block sits in front of a slow-polling I2C slave engine. It watches the SDA and SCL lines and looks for the bus to show a start or repeated start that the engine can act on. An SDA line held low (such as the long low stretch of a start byte) opens a bounded search window. Inside that window the block waits for SDA to return high and then fall again. A fall while SCL is high is a valid start and produces a one-cycle `start_det` pulse. A fall while SCL is low is a false start and produces a one-cycle `false_start` pulse. If the window runs out first, the block goes back to idle and reports nothing.

Both bus lines pass through a multi-stage synchronizer before any edge is taken, so all decisions are made on the system clock. The window length is loaded from the `timeout_cfg` input each time the block arms. The value 0xF0 gives roughly 30 µs at the intended clock. Once the downstream engine has decoded a start byte, it can pulse `rearm` to reopen the window directly. Address decoding, data shifting and acknowledge driving belong to the downstream engine.

Top module: `bus_start_hunter`

## Requirements
- R1: While `rst` is high at a rising clock edge, after that edge `window_open`, `start_det` and `false_start` are 0 and the window counter is 0. The synchronizer stages reset to the released (high) bus level.
- R2: When idle, a synchronized SDA low level arms the window at the next clock edge (`window_open` = 1). A change on the pins reaches the decision logic after two synchronizer stages.
- R3: When armed, the block accepts a start only after SDA has been seen high and then falls while SCL is high. `start_det` is then 1 for exactly one cycle, after the third rising edge that follows the SDA change on the pin.
- R4: When armed and past the SDA-high phase, an SDA fall while SCL is low gives a one-cycle `false_start`, no `start_det`, and a return to idle.
- R5: The window lasts `timeout_cfg`+1 clock cycles from arming. When it expires without a fall, the block returns to idle and pulses neither output.
- R6: A `rearm` high at a clock edge puts the block in the SDA-high wait phase from any state and reloads the window from `timeout_cfg`.
- R7: `start_det` and `false_start` are never high in the same cycle, and neither is high for two cycles in a row.
- R8: When idle with SDA high, SCL activity alone does not arm the block and produces no pulse.
- R9: `timeout_cfg` is sampled only at arming (R2) and at rearm (R6). A change during an open window does not change that window's length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sda_in | input | 1 | Raw SDA line level |
| scl_in | input | 1 | Raw SCL line level |
| rearm | input | 1 | Reopen the window from the engine (clock domain of `clk`) |
| timeout_cfg | input | CNT_W (8) | Window length minus one, in clock cycles |
| start_det | output | 1 | One-cycle pulse on a valid start or repeated start |
| false_start | output | 1 | One-cycle pulse when SDA falls while SCL is low |
| window_open | output | 1 | High while the search window is armed |

## Verification
The assertions assume that `rearm` and `timeout_cfg` are synchronous to `clk`. They also assume that each level on the raw bus pins is held long enough to pass the synchronizer, so that every fall seen inside the block matches one fall on the pin. The bench changes all inputs on the falling clock edge and holds each bus level for at least one full cycle. It counts pulses and open-window cycles shortly after each rising edge, so the expected window lengths and latencies follow directly from the register count through the synchronizer and the state register.

// File: rtl/bus_start_hunter_pkg.sv
package bus_start_hunter_pkg;

    typedef enum logic [1:0] {
        HUNT_IDLE      = 2'd0,
        HUNT_WAIT_HIGH = 2'd1,
        HUNT_WAIT_FALL = 2'd2
    } hunt_state_e;

    function automatic logic is_armed(hunt_state_e s);
        return s != HUNT_IDLE;
    endfunction

endpackage

// File: rtl/sh_line_sync.sv
module sh_line_sync #(
    parameter int                LINES   = 2,
    parameter int                STAGES  = 2,
    parameter logic [LINES-1:0]  RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LINES-1:0] din,
    output logic [LINES-1:0] dout
);
    localparam int LAST = STAGES - 1;

    typedef struct packed {
        logic [STAGES-1:0][LINES-1:0] pipe;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d = sync_q;
        sync_d.pipe[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            sync_d.pipe[i] = sync_q.pipe[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q.pipe <= {STAGES{RST_VAL}};
        end else begin
            sync_q <= sync_d;
        end
    end

    assign dout = sync_q.pipe[LAST];

    // R1: the output of the synchronizer shows the released bus after reset
    assert_sync_reset_R1: assert property (@(posedge clk) rst |=> (dout == RST_VAL));

endmodule

// File: rtl/sh_hunt_fsm.sv
module sh_hunt_fsm
    import bus_start_hunter_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sda_s,
    input  logic             scl_s,
    input  logic             rearm,
    input  logic [CNT_W-1:0] cfg,
    output logic             start_pulse,
    output logic             false_pulse,
    output logic             hunting
);
    localparam logic [CNT_W-1:0] CNT_ZERO = '0;
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    typedef struct packed {
        hunt_state_e      state;
        logic [CNT_W-1:0] cnt;
        logic             sda_prev;
        logic             start;
        logic             fls;
    } hunt_t;

    hunt_t hunt_d, hunt_q;
    logic  fall_evt;
    logic  expired;

    assign fall_evt = hunt_q.sda_prev & ~sda_s;
    assign expired  = (hunt_q.cnt == CNT_ZERO);

    always_comb begin
        hunt_d          = hunt_q;
        hunt_d.start    = 1'b0;
        hunt_d.fls      = 1'b0;
        hunt_d.sda_prev = sda_s;
        if (rearm) begin
            hunt_d.state = HUNT_WAIT_HIGH;
            hunt_d.cnt   = cfg;
        end else begin
            unique case (hunt_q.state)
                HUNT_IDLE: begin
                    hunt_d.cnt = CNT_ZERO;
                    if (!sda_s) begin
                        hunt_d.state = HUNT_WAIT_HIGH;
                        hunt_d.cnt   = cfg;
                    end
                end
                HUNT_WAIT_HIGH: begin
                    if (expired) begin
                        hunt_d.state = HUNT_IDLE;
                    end else begin
                        hunt_d.cnt = hunt_q.cnt - CNT_ONE;
                        if (sda_s) begin
                            hunt_d.state = HUNT_WAIT_FALL;
                        end
                    end
                end
                HUNT_WAIT_FALL: begin
                    if (fall_evt) begin
                        hunt_d.state = HUNT_IDLE;
                        hunt_d.cnt   = CNT_ZERO;
                        hunt_d.start = scl_s;
                        hunt_d.fls   = ~scl_s;
                    end else if (expired) begin
                        hunt_d.state = HUNT_IDLE;
                    end else begin
                        hunt_d.cnt = hunt_q.cnt - CNT_ONE;
                    end
                end
                default: begin
                    hunt_d.state = HUNT_IDLE;
                    hunt_d.cnt   = CNT_ZERO;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hunt_q.state    <= HUNT_IDLE;
            hunt_q.cnt      <= CNT_ZERO;
            hunt_q.sda_prev <= 1'b1;
            hunt_q.start    <= 1'b0;
            hunt_q.fls      <= 1'b0;
        end else begin
            hunt_q <= hunt_d;
        end
    end

    assign start_pulse = hunt_q.start;
    assign false_pulse = hunt_q.fls;
    assign hunting     = is_armed(hunt_q.state);

    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (!hunting && hunt_q.cnt == CNT_ZERO && !start_pulse && !false_pulse));

    assert_arm_on_low_R2: assert property (@(posedge clk) disable iff (rst)
        (!hunting && !sda_s && !rearm) |=> (hunting && hunt_q.cnt == $past(cfg)));

    assert_start_scl_high_R3: assert property (@(posedge clk) disable iff (rst)
        start_pulse |-> ($past(scl_s) && !hunting));

    assert_false_scl_low_R4: assert property (@(posedge clk) disable iff (rst)
        false_pulse |-> (!$past(scl_s) && !hunting));

    assert_window_shrinks_R5: assert property (@(posedge clk) disable iff (rst)
        (hunting && !rearm && hunt_q.cnt != CNT_ZERO) |=>
            (!hunting || hunt_q.cnt == $past(hunt_q.cnt) - CNT_ONE));

    assert_window_closes_R5: assert property (@(posedge clk) disable iff (rst)
        (hunting && !rearm && expired && !fall_evt) |=>
            (!hunting && !start_pulse && !false_pulse));

    assert_rearm_reload_R6: assert property (@(posedge clk) disable iff (rst)
        rearm |=> (hunting && hunt_q.cnt == $past(cfg)));

    assert_exclusive_R7: assert property (@(posedge clk) disable iff (rst)
        !(start_pulse && false_pulse));

    assert_start_width_R7: assert property (@(posedge clk) disable iff (rst)
        start_pulse |=> !start_pulse);

    assert_false_width_R7: assert property (@(posedge clk) disable iff (rst)
        false_pulse |=> !false_pulse);

    assert_idle_ignores_scl_R8: assert property (@(posedge clk) disable iff (rst)
        (!hunting && sda_s && !rearm) |=> !hunting);

endmodule

// File: rtl/bus_start_hunter.sv
module bus_start_hunter #(
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sda_in,
    input  logic             scl_in,
    input  logic             rearm,
    input  logic [CNT_W-1:0] timeout_cfg,
    output logic             start_det,
    output logic             false_start,
    output logic             window_open
);
    localparam int LINES   = 2;
    localparam int IDX_SDA = 0;
    localparam int IDX_SCL = 1;

    logic [LINES-1:0] raw_lines;
    logic [LINES-1:0] sync_lines;

    assign raw_lines[IDX_SDA] = sda_in;
    assign raw_lines[IDX_SCL] = scl_in;

    sh_line_sync #(
        .LINES   (LINES),
        .STAGES  (SYNC_STAGES),
        .RST_VAL ({LINES{1'b1}})
    ) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (raw_lines),
        .dout (sync_lines)
    );

    sh_hunt_fsm #(
        .CNT_W (CNT_W)
    ) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .sda_s       (sync_lines[IDX_SDA]),
        .scl_s       (sync_lines[IDX_SCL]),
        .rearm       (rearm),
        .cfg         (timeout_cfg),
        .start_pulse (start_det),
        .false_pulse (false_start),
        .hunting     (window_open)
    );

endmodule

// File: tb/bus_start_hunter_bench.sv
module bus_start_hunter_bench;
    localparam int CNT_W = 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             sda = 1'b1;
    logic             scl = 1'b1;
    logic             rearm = 1'b0;
    logic [CNT_W-1:0] cfg = 8'd10;
    logic             start_det, false_start, window_open;

    int total = 0;
    int bad   = 0;
    int n_start = 0;
    int n_false = 0;
    int n_open  = 0;

    always #4 clk = ~clk;

    bus_start_hunter #(.CNT_W(CNT_W), .SYNC_STAGES(2)) u_bus_start_hunter (
        .clk(clk), .rst(rst), .sda_in(sda), .scl_in(scl), .rearm(rearm),
        .timeout_cfg(cfg), .start_det(start_det), .false_start(false_start),
        .window_open(window_open)
    );

    // Post-edge counters, sampled 1 ns after each rising edge
    always @(posedge clk) begin
        #1;
        if (start_det)   n_start++;
        if (false_start) n_false++;
        if (window_open) n_open++;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_counts();
        n_start = 0; n_false = 0; n_open = 0;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_rearm();
        rearm = 1'b1;
        @(negedge clk);
        rearm = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        settle(3);
        rst = 1'b0;
        check(window_open == 1'b0, "R1 window_open", window_open, 0);
        check(start_det == 1'b0,   "R1 start_det", start_det, 0);
        check(false_start == 1'b0, "R1 false_start", false_start, 0);
        settle(4);
        check(window_open == 1'b0, "R1 idle after release", window_open, 0);
    endtask

    task automatic t_scl_only();
        clear_counts();
        for (int i = 0; i < 12; i++) begin
            scl = ~scl;
            settle(3);
        end
        scl = 1'b1;
        settle(4);
        check(n_open == 0,  "R8 scl toggles no arm", n_open, 0);
        check(n_start == 0, "R8 no start", n_start, 0);
        check(n_false == 0, "R8 no false", n_false, 0);
    endtask

    task automatic t_window_len();
        cfg = 8'd10;
        clear_counts();
        sda = 1'b0;
        @(negedge clk);
        sda = 1'b1;
        settle(3);
        check(window_open == 1'b1, "R2 arm on sda low", window_open, 1);
        settle(30);
        check(n_open == 11, "R5 window length", n_open, 11);
        check(n_start == 0 && n_false == 0, "R5 silent expiry", n_start + n_false, 0);
    endtask

    task automatic t_cfg_change();
        cfg = 8'd10;
        clear_counts();
        sda = 1'b0;
        @(negedge clk);
        sda = 1'b1;
        settle(4);
        cfg = 8'd200;
        settle(30);
        check(n_open == 11, "R9 cfg change mid window", n_open, 11);
        cfg = 8'd10;
    endtask

    task automatic t_start_latency();
        cfg = 8'd20;
        clear_counts();
        pulse_rearm();
        @(negedge clk);
        sda = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(start_det == 1'b1,   "R3 start pulse latency", start_det, 1);
        check(false_start == 1'b0, "R3 no false with scl high", false_start, 0);
        @(negedge clk);
        check(start_det == 1'b0,   "R7 start pulse one cycle", start_det, 0);
        sda = 1'b1;
        settle(40);
        check(n_start == 1, "R3 single start", n_start, 1);
    endtask

    task automatic t_false_start();
        cfg = 8'd20;
        clear_counts();
        pulse_rearm();
        @(negedge clk);
        scl = 1'b0;
        settle(3);
        sda = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(false_start == 1'b1, "R4 false pulse", false_start, 1);
        check(start_det == 1'b0,   "R4 no start with scl low", start_det, 0);
        @(negedge clk);
        check(false_start == 1'b0, "R7 false pulse one cycle", false_start, 0);
        sda = 1'b1;
        scl = 1'b1;
        settle(40);
        check(n_false == 1 && n_start == 0, "R4 counts", n_false * 10 + n_start, 10);
    endtask

    task automatic t_rearm_reload();
        cfg = 8'd10;
        clear_counts();
        pulse_rearm();
        settle(3);
        pulse_rearm();
        settle(30);
        check(n_open == 15, "R6 rearm reloads window", n_open, 15);
        check(n_start == 0 && n_false == 0, "R6 no pulses", n_start + n_false, 0);
    endtask

    task automatic t_late_fall();
        cfg = 8'd6;
        clear_counts();
        pulse_rearm();
        settle(14);
        sda = 1'b0;
        settle(4);
        check(n_start == 0, "R5 fall after expiry ignored", n_start, 0);
        sda = 1'b1;
        settle(20);
    endtask

    task automatic scl_bit(input bit b);
        scl = 1'b0;
        settle(2);
        sda = b;
        settle(2);
        scl = 1'b1;
        settle(4);
    endtask

    task automatic t_start_byte();
        cfg = 8'hF0;
        clear_counts();
        sda = 1'b0;             // initial start while scl high
        settle(4);
        for (int i = 0; i < 7; i++) scl_bit(1'b0);
        scl_bit(1'b1);
        scl_bit(1'b1);          // acknowledge slot left high
        scl = 1'b0;
        settle(2);
        scl = 1'b1;
        settle(3);
        sda = 1'b0;             // repeated start
        settle(6);
        check(n_start == 1, "R3 repeated start after start byte", n_start, 1);
        check(n_false == 0, "R4 no false during start byte", n_false, 0);
        sda = 1'b1;
        settle(260);
        check(window_open == 1'b0, "R5 back to idle", window_open, 0);
        cfg = 8'd10;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_scl_only();
        t_window_len();
        t_cfg_change();
        t_start_latency();
        t_false_start();
        t_rearm_reload();
        t_late_fall();
        t_start_byte();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule